// File: doc/BRIEF.md
# Streaming Prefix-Sum Vector Operator

This block is a custom operator that hangs off a multi-lane vector datapath, in parallel with the datapath's own three-stage ALU pipeline. On each cycle it may accept one wave, which holds one element per lane. Each wave arrives with a valid flag, per-lane enable flags and a start-of-vector flag. For each enabled element the block returns the running total of operand A in element order. Lane 0 comes first within a wave. The total keeps growing across successive waves until a new vector begins, so a vector of any length is summed in a streaming fashion.

A 2-bit size field selects the element width, and all arithmetic wraps to that width. A 2-bit opcode selects the function: inclusive prefix sum, exclusive prefix sum, or pass-through of operand A. Results leave exactly three clock edges after the wave enters. Byte enables travel with the results and mark which result bytes the writeback path may store, so a short final wave or a disabled lane writes nothing.

Top module: `psum_stream_unit`

## Requirements
- R1: With opcode 0 (inclusive sum), the result of each enabled lane is the wrapped sum of the carried total and all enabled operand-A elements of the wave from lane 0 up to and including that lane.
- R2: After a valid wave with opcode 0 or 2, the carried total becomes the wrapped sum of the old carried total and every enabled element of that wave, so sums continue across waves.
- R3: A wave with valid and start both high uses a carried total of zero. The carried total is cleared even when the opcode is 1 or 3. Start has no effect while valid is low.
- R4: While valid is low, the carried total is held and, three edges later, all byte enables and all result bits are zero.
- R5: A lane whose enable bit is low adds zero to the sum. Its result bits and its byte enables are zero.
- R6: The size field selects the element width: 00 is 8 bits, 01 is 16 bits, and 10 or 11 is 32 bits. Each lane uses the low bits of its 32-bit slot. Sums wrap modulo the element width and bits above it read zero. An enabled lane asserts the byte enables of its low 1, 2 or 4 bytes, where bit 4*lane+k covers byte k of that lane.
- R7: Opcodes 1 and 3 return each enabled lane's operand A, truncated to the element width, and leave the carried total unchanged apart from the clear in R3.
- R8: With opcode 2 (exclusive sum), each enabled lane returns the carried total plus the enabled elements of lower-numbered lanes only.
- R9: A wave presented before clock edge k appears on the outputs after edge k+2, which is three register stages, and never earlier.
- R10: During and after reset, and before any wave, the outputs are zero and the carried total is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A wave is present this cycle |
| start_i | input | 1 | This wave begins a new vector |
| en_i | input | LANES | Per-lane element enables |
| op_i | input | 2 | 0 inclusive, 1 pass, 2 exclusive, 3 pass |
| size_i | input | 2 | 00 byte, 01 short, 10/11 word |
| a_i | input | LANES*LANE_W | Operand A, lane 0 in the low bits |
| res_o | output | LANES*LANE_W | Results, lane 0 in the low bits |
| be_o | output | LANES*LANE_W/8 | Result byte enables |

## Verification
On every cycle the assertions check the following properties. The carried total holds while no wave is present, and a start clears it. Byte enables are zero three cycles after an idle cycle or for a disabled lane. Every lane's enable pattern is a contiguous group of low bytes, and a byte-sized wave never lights an upper byte. Pass-through echoes operand A at the right latency. The arithmetic can only be shown by the bench's scenarios, run against an independent per-wave model. These scenarios cover sums crossing lane boundaries, totals carried over multi-wave vectors, wrap at 8 and 16 bits, the exclusive offset, and restarts in the middle of a stream.

// File: rtl/psum_pkg.sv
package psum_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } elem_size_e;

  typedef enum logic [1:0] {
    OP_INCL  = 2'd0,
    OP_PASS  = 2'd1,
    OP_EXCL  = 2'd2,
    OP_PASS2 = 2'd3
  } psum_op_e;

  // active bytes per lane for a size code, capped by the lane width
  function automatic int unsigned size_bytes(logic [1:0] sz, int unsigned lane_bytes);
    int unsigned n;
    case (sz)
      SZ_BYTE: n = 1;
      SZ_HALF: n = 2;
      default: n = 4;
    endcase
    return (n > lane_bytes) ? lane_bytes : n;
  endfunction

  function automatic logic is_sum_op(logic [1:0] op);
    return (op == OP_INCL) || (op == OP_EXCL);
  endfunction
endpackage

// File: rtl/psum_in_stage.sv
module psum_in_stage
  import psum_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    start_i,
  input  logic [LANES-1:0]        en_i,
  input  logic [1:0]              op_i,
  input  logic [1:0]              size_i,
  input  logic [LANES*LANE_W-1:0] a_i,
  output logic                    vld_o,
  output logic                    start_o,
  output logic [LANES-1:0]        en_o,
  output logic [1:0]              op_o,
  output logic [1:0]              size_o,
  output logic [LANES*LANE_W-1:0] a_o
);
  localparam int unsigned LANE_BYTES = LANE_W / 8;

  logic [LANE_W-1:0]       mask;
  logic [LANES*LANE_W-1:0] a_m;

  always_comb begin
    mask = '0;
    for (int unsigned b = 0; b < LANE_BYTES; b++)
      if (b < size_bytes(size_i, LANE_BYTES)) mask[b*8 +: 8] = 8'hFF;
  end

  // disabled lanes are zeroed here so they add nothing downstream
  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign a_m[l*LANE_W +: LANE_W] = en_i[l] ? (a_i[l*LANE_W +: LANE_W] & mask) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      start_o <= 1'b0;
      en_o    <= '0;
      op_o    <= '0;
      size_o  <= '0;
      a_o     <= '0;
    end else begin
      vld_o   <= valid_i;
      start_o <= start_i;
      en_o    <= en_i;
      op_o    <= op_i;
      size_o  <= size_i;
      a_o     <= a_m;
    end
  end
endmodule

// File: rtl/psum_chain.sv
module psum_chain
  import psum_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic                    start_i,
  input  logic [LANES-1:0]        en_i,
  input  logic [1:0]              op_i,
  input  logic [1:0]              size_i,
  input  logic [LANES*LANE_W-1:0] a_i,
  output logic                    vld_o,
  output logic [LANES-1:0]        en_o,
  output logic [1:0]              size_o,
  output logic [LANES*LANE_W-1:0] res_o
);
  localparam int unsigned LANE_BYTES = LANE_W / 8;

  logic [LANE_W-1:0]       carry_q, carry_d, run;
  logic [LANE_W-1:0]       mask;
  logic [LANES*LANE_W-1:0] res_d;

  always_comb begin
    mask = '0;
    for (int unsigned b = 0; b < LANE_BYTES; b++)
      if (b < size_bytes(size_i, LANE_BYTES)) mask[b*8 +: 8] = 8'hFF;
  end

  // ripple across lanes; upper bits are masked, so wrap falls out naturally
  always_comb begin
    logic [LANE_W-1:0] pick;
    run   = start_i ? '0 : carry_q;
    res_d = '0;
    for (int unsigned l = 0; l < LANES; l++) begin
      case (op_i)
        OP_INCL: pick = run + a_i[l*LANE_W +: LANE_W];
        OP_EXCL: pick = run;
        default: pick = a_i[l*LANE_W +: LANE_W];
      endcase
      run = run + a_i[l*LANE_W +: LANE_W];
      if (vld_i && en_i[l]) res_d[l*LANE_W +: LANE_W] = pick & mask;
    end
  end

  always_comb begin
    carry_d = carry_q;
    if (vld_i && is_sum_op(op_i)) carry_d = run;
    else if (vld_i && start_i)    carry_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q <= '0;
      vld_o   <= 1'b0;
      en_o    <= '0;
      size_o  <= '0;
      res_o   <= '0;
    end else begin
      carry_q <= carry_d;
      vld_o   <= vld_i;
      en_o    <= en_i;
      size_o  <= size_i;
      res_o   <= res_d;
    end
  end

  // R4
  carry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(carry_q));

  // R3
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && start_i && !is_sum_op(op_i)) |=> (carry_q == '0));

  // R7
  pass_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !start_i && !is_sum_op(op_i)) |=> $stable(carry_q));
endmodule

// File: rtl/psum_out_stage.sv
module psum_out_stage
  import psum_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          vld_i,
  input  logic [LANES-1:0]              en_i,
  input  logic [1:0]                    size_i,
  input  logic [LANES*LANE_W-1:0]       res_i,
  output logic [LANES*LANE_W-1:0]       res_o,
  output logic [LANES*(LANE_W/8)-1:0]   be_o
);
  localparam int unsigned LANE_BYTES = LANE_W / 8;

  logic [LANE_BYTES-1:0]         lane_be;
  logic [LANES*LANE_BYTES-1:0]   be_d;

  always_comb begin
    lane_be = '0;
    for (int unsigned b = 0; b < LANE_BYTES; b++)
      if (b < size_bytes(size_i, LANE_BYTES)) lane_be[b] = 1'b1;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_be
    assign be_d[l*LANE_BYTES +: LANE_BYTES] = (vld_i && en_i[l]) ? lane_be : '0;

    // R6
    be_contig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot({1'b0, be_o[l*LANE_BYTES +: LANE_BYTES]} + 1'b1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0;
      be_o  <= '0;
    end else begin
      res_o <= res_i;
      be_o  <= be_d;
    end
  end
endmodule

// File: rtl/psum_stream_unit.sv
module psum_stream_unit
  import psum_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic                        start_i,
  input  logic [LANES-1:0]            en_i,
  input  logic [1:0]                  op_i,
  input  logic [1:0]                  size_i,
  input  logic [LANES*LANE_W-1:0]     a_i,
  output logic [LANES*LANE_W-1:0]     res_o,
  output logic [LANES*(LANE_W/8)-1:0] be_o
);
  localparam int unsigned LANE_BYTES = LANE_W / 8;

  logic                    s1_vld, s1_start;
  logic [LANES-1:0]        s1_en;
  logic [1:0]              s1_op, s1_size;
  logic [LANES*LANE_W-1:0] s1_a;
  logic                    s2_vld;
  logic [LANES-1:0]        s2_en;
  logic [1:0]              s2_size;
  logic [LANES*LANE_W-1:0] s2_res;

  psum_in_stage #(.LANES(LANES), .LANE_W(LANE_W)) i_in (
    .clk_i, .rst_ni, .valid_i, .start_i, .en_i, .op_i, .size_i, .a_i,
    .vld_o(s1_vld), .start_o(s1_start), .en_o(s1_en), .op_o(s1_op),
    .size_o(s1_size), .a_o(s1_a)
  );

  psum_chain #(.LANES(LANES), .LANE_W(LANE_W)) i_chain (
    .clk_i, .rst_ni, .vld_i(s1_vld), .start_i(s1_start), .en_i(s1_en),
    .op_i(s1_op), .size_i(s1_size), .a_i(s1_a),
    .vld_o(s2_vld), .en_o(s2_en), .size_o(s2_size), .res_o(s2_res)
  );

  psum_out_stage #(.LANES(LANES), .LANE_W(LANE_W)) i_out (
    .clk_i, .rst_ni, .vld_i(s2_vld), .en_i(s2_en), .size_i(s2_size),
    .res_i(s2_res), .res_o, .be_o
  );

  // edges since reset, saturating; gates the three-deep look-back
  logic [1:0] since_rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 since_rst_q <= '0;
    else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
  end
  logic hist_ok;
  assign hist_ok = (since_rst_q == 2'd3);

  // R4
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_ok && !$past(valid_i, 3)) |-> (be_o == '0 && res_o == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    // R5
    lane_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hist_ok && !$past(en_i[l], 3)) |->
        (be_o[l*LANE_BYTES +: LANE_BYTES] == '0 && res_o[l*LANE_W +: LANE_W] == '0));

    // R6
    byte_be_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hist_ok && $past(size_i, 3) == SZ_BYTE) |->
        (be_o[l*LANE_BYTES + 1 +: LANE_BYTES - 1] == '0));

    // R7
    pass_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hist_ok && $past(valid_i && en_i[l], 3) && $past(size_i[1], 3) &&
       $past(op_i == OP_PASS || op_i == OP_PASS2, 3)) |->
        (res_o[l*LANE_W +: LANE_W] == $past(a_i[l*LANE_W +: LANE_W], 3)));
  end
endmodule

// File: tb/test_psum_stream_unit.sv
`timescale 1ns/1ps
module test_psum_stream_unit;
  localparam int LANES = 4;
  localparam int W     = 32;
  localparam int NB    = W / 8;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  valid = 1'b0, start = 1'b0;
  logic [LANES-1:0]      en = '0;
  logic [1:0]            op = '0, size = 2'b10;
  logic [LANES*W-1:0]    a = '0;
  logic [LANES*W-1:0]    res;
  logic [LANES*NB-1:0]   be;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R10";
  bit    cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  psum_stream_unit #(.LANES(LANES), .LANE_W(W)) i_psum_stream_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .start_i(start), .en_i(en),
    .op_i(op), .size_i(size), .a_i(a), .res_o(res), .be_o(be)
  );

  // behavioural model: one wave per edge, results delayed three edges
  logic [31:0]         m_carry;
  logic [LANES*W-1:0]  q_res [3];
  logic [LANES*NB-1:0] q_be  [3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_carry = 0;
      for (int i = 0; i < 3; i++) begin q_res[i] = '0; q_be[i] = '0; end
    end else begin
      logic [31:0] msk, run, el, val;
      logic [LANES*W-1:0]  r;
      logic [LANES*NB-1:0] b;
      int nb;
      nb  = (size == 2'b00) ? 1 : (size == 2'b01) ? 2 : 4;
      msk = (nb == 1) ? 32'hFF : (nb == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
      run = start ? 32'd0 : m_carry;
      r = '0; b = '0;
      for (int l = 0; l < LANES; l++) begin
        el = en[l] ? (a[l*W +: W] & msk) : 32'd0;
        if (op == 2'd0)      val = run + el;
        else if (op == 2'd2) val = run;
        else                 val = el;
        run = run + el;
        if (valid && en[l]) begin
          r[l*W +: W] = val & msk;
          for (int k = 0; k < nb; k++) b[l*NB + k] = 1'b1;
        end
      end
      if (valid && (op == 2'd0 || op == 2'd2)) m_carry = run;
      else if (valid && start)                 m_carry = 0;
      q_res[2] = q_res[1]; q_be[2] = q_be[1];
      q_res[1] = q_res[0]; q_be[1] = q_be[0];
      q_res[0] = r;        q_be[0] = b;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      n_chk++;
      if (res !== q_res[2] || be !== q_be[2]) begin
        n_fail++;
        $display("FAIL %s: res=%h be=%h expected res=%h be=%h", cur_req, res, be, q_res[2], q_be[2]);
      end
    end
  end

  task automatic check(string req, logic [LANES*W-1:0] gr, logic [LANES*NB-1:0] gb,
                       logic [LANES*W-1:0] er, logic [LANES*NB-1:0] eb);
    n_chk++;
    if (gr !== er || gb !== eb) begin
      n_fail++;
      $display("FAIL %s: res=%h be=%h expected res=%h be=%h", req, gr, gb, er, eb);
    end
  endtask

  task automatic wave(bit v, bit s, logic [LANES-1:0] e, logic [1:0] o, logic [1:0] sz,
                      logic [31:0] a0, logic [31:0] a1, logic [31:0] a2, logic [31:0] a3);
    valid = v; start = s; en = e; op = o; size = sz;
    a = {a3, a2, a1, a0};
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) wave(0, 0, '0, 0, 2, 0, 0, 0, 0);
  endtask

  task automatic rnd_waves(int n, logic [1:0] o, logic [1:0] sz, bit rnd_en);
    for (int i = 0; i < n; i++)
      wave(1, (i == 0), rnd_en ? LANES'($urandom) : '1, o, sz,
           $urandom, $urandom, $urandom, $urandom);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", res, be, '0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", res, be, '0, '0);
    cmp_on = 1'b1;
    idle(3);

    // R9: single wave 1+2+3+4, visible after third edge only
    cmp_on = 1'b0;
    wave(1, 1, 4'hF, 0, 2, 1, 2, 3, 4);
    valid = 0; en = '0;
    check("R9", res, be, '0, '0);
    @(negedge clk);
    check("R9", res, be, '0, '0);
    @(negedge clk);
    check("R9", res, be, {32'd10, 32'd6, 32'd3, 32'd1}, '1);
    @(negedge clk);
    cmp_on = 1'b1;
    idle(3);

    cur_req = "R1";  wave(1, 1, 4'hF, 0, 2, 5, 7, 11, 13); rnd_waves(3, 0, 2, 0);
    cur_req = "R2";  rnd_waves(6, 0, 2, 0); wave(1, 0, 4'hF, 0, 2, 1, 1, 1, 1);
    cur_req = "R3";  wave(1, 1, 4'hF, 0, 2, 9, 9, 9, 9); wave(1, 1, 4'hF, 1, 2, 3, 3, 3, 3);
                     wave(1, 0, 4'hF, 0, 2, 1, 2, 3, 4); wave(0, 1, 4'hF, 0, 2, 7, 7, 7, 7);
                     wave(1, 0, 4'hF, 0, 2, 1, 1, 1, 1);
    cur_req = "R4";  wave(0, 0, 4'hF, 0, 2, 32'hDEAD, 1, 2, 3); idle(2);
                     wave(1, 0, 4'hF, 0, 2, 1, 1, 1, 1); idle(3);
    cur_req = "R5";  wave(1, 1, 4'b1010, 0, 2, 100, 1, 100, 2); rnd_waves(8, 0, 2, 1);
    cur_req = "R6";  wave(1, 1, 4'hF, 0, 0, 32'h1FF, 32'h01, 32'hFE, 32'h03);
                     wave(1, 1, 4'hF, 0, 1, 32'hFFFF, 32'h2, 32'h8000, 32'h8000);
                     wave(1, 0, 4'hF, 0, 3, 32'hFFFF_FFFF, 1, 2, 3);
                     rnd_waves(5, 0, 0, 1); rnd_waves(5, 2, 1, 1);
    cur_req = "R7";  wave(1, 1, 4'hF, 0, 2, 1, 2, 3, 4); rnd_waves(3, 1, 2, 1);
                     wave(1, 0, 4'hF, 3, 0, 32'h1234, 5, 6, 7); wave(1, 0, 4'hF, 0, 2, 1, 0, 0, 0);
    cur_req = "R8";  wave(1, 1, 4'hF, 2, 2, 5, 6, 7, 8); wave(1, 0, 4'hF, 2, 2, 1, 1, 1, 1);
                     rnd_waves(4, 2, 2, 1);
    cur_req = "R2";
    for (int i = 0; i < 200; i++)
      wave($urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0, LANES'($urandom),
           2'($urandom), 2'($urandom), $urandom, $urandom, $urandom, $urandom);
    idle(4);
    cmp_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule